// File: doc/BRIEF.md
# Configurable SPI Master Channel

This block is one SPI master channel. Software reaches it through a simple synchronous register port: a write strobe with address and data, plus a read strobe whose data is presented combinationally for the addressed register. The channel serializes words of 4 to 32 bits onto a serial data output, MSB first. At the same time it collects bits from the serial data input. The serial clock comes from the block clock through a power-of-two divider, and all four clock polarity/phase combinations are supported.

Software controls the chip select directly through a force bit in the configuration register, and a polarity bit chooses its active level. The chip select does not follow channel enable. The channel runs in one of three transfer modes: full duplex, receive-only (the channel keeps shifting whenever its receive register is empty, resending the last transmit value), or transmit-only (received bits are discarded). Two request lines let an external DMA engine refill the transmit register and drain the receive register.

Top module: `spich_top`

## Requirements
- R1: Register byte addresses are configuration 0x2C, status 0x30, control 0x34, transmit 0x38, receive 0x3C. After reset the status register reads 0x6 (bit 0 receive-full = 0, bit 1 transmit-empty = 1, bit 2 end-of-transfer = 1), the serial clock is low and the chip select is low.
- R2: In full-duplex (configuration bits 13:12 = 00) or transmit-only (10) mode, a write to the transmit register while control bit 0 (enable) is set starts a word that leaves on the serial output MSB first. A transmit write while the channel is disabled is ignored.
- R3: Configuration bits 11:7 hold the word length minus one. A field value below 3 is treated as 3, so the shortest word is 4 bits.
- R4: Configuration bit 0 is clock phase and bit 1 is clock polarity. The serial clock idles at the polarity level. With phase 0, data is sampled on the leading edge; with phase 1, on the trailing edge.
- R5: Configuration bits 5:2 (divider, 0..15) set each serial clock half period to 2^divider block-clock cycles.
- R6: Configuration bit 20 forces the chip select to its active level, and bit 6 set makes the active level low (clear: high). With bit 20 clear the chip select sits at its inactive level, whatever the enable bit is.
- R7: In full-duplex mode each completed word is stored in the receive register with status bit 0 set. A read strobe at the receive address clears bit 0.
- R8: In receive-only mode (01) the enabled channel starts a word whenever the receive register is empty and busy is clear, sending the last value written to the transmit register. It does not start while the receive register is full.
- R9: Clearing control bit 0 discards any received word (status bit 0 reads 0) and aborts a word in flight.
- R10: In full-duplex mode a pending transmit word is not started while the receive register is full. It starts once the receive register is read, so no received word is overwritten.
- R11: Configuration bit 14 drives the transmit request while the channel is enabled, not in receive-only mode, and the transmit register is empty. Bit 15 drives the receive request while the receive register is full.
- R12: In transmit-only mode received bits are not stored. Status bit 2 (no word pending or shifting) is separate from bit 1: while a word shifts, bit 1 is 1 and bit 2 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and divider reference |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effect on the receive register) |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | 1 | Chip select |
| txDmaReq | output | 1 | Transmit refill request |
| rxDmaReq | output | 1 | Receive drain request |

## Verification
A bad transmit-full or receive-full flag shows up at once in the status register. It also stalls or doubles serial words within one word time, and the bench sees this as a wrong count of bits captured from the serial output. Errors in the divider, the edge counter or the phase handling change the serial clock period or the sample edge within the first two bit times. With the serial input tied to the inverted serial output, they also corrupt the word read back. An overwrite or a missed discard in the receive register shows up as a wrong receive value or a wrong bit 0 right after the stalling or disabling step.

// File: rtl/spich_pkg.sv
package spich_pkg;
  localparam logic [7:0] ADDR_CFG    = 8'h2C;
  localparam logic [7:0] ADDR_STATUS = 8'h30;
  localparam logic [7:0] ADDR_CTRL   = 8'h34;
  localparam logic [7:0] ADDR_TX     = 8'h38;
  localparam logic [7:0] ADDR_RX     = 8'h3C;

  // configuration bit positions
  localparam int CFG_PHASE  = 0;
  localparam int CFG_POL    = 1;
  localparam int CFG_DIV_LO = 2;
  localparam int CFG_CSLOW  = 6;
  localparam int CFG_WL_LO  = 7;
  localparam int CFG_MODE_LO = 12;
  localparam int CFG_TXREQ  = 14;
  localparam int CFG_RXREQ  = 15;
  localparam int CFG_FORCE  = 20;

  typedef enum logic [1:0] {
    XFER_DUPLEX = 2'b00,
    XFER_RXONLY = 2'b01,
    XFER_TXONLY = 2'b10,
    XFER_RSVD   = 2'b11
  } xferMode_e;

  typedef struct packed {
    logic start;
    logic abort;
  } dpCmd_t;
endpackage

// File: rtl/spich_dp.sv
module spich_dp
  import spich_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CLKD_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCmd_t                 cmd,
  input  logic [DW-1:0]          loadWord,
  input  logic [$clog2(DW)-1:0]  wlm1,
  input  logic [CLKD_W-1:0]      clkd,
  input  logic                   cpol,
  input  logic                   cpha,
  input  logic                   miso,
  output logic                   busy,
  output logic                   done,
  output logic [DW-1:0]          rxWord,
  output logic                   sclk,
  output logic                   mosi
);
  localparam int WL_W   = $clog2(DW);
  localparam int EDGE_W = WL_W + 1;
  localparam int DIV_W  = (1 << CLKD_W) - 1;

  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divLim;
  logic [EDGE_W-1:0] edgeCnt;
  logic [DW-1:0]     txSh;
  logic [DW-1:0]     rxSh;
  logic              phase;
  logic              mosiQ;
  logic              tick;
  logic              lastEdge;
  logic              sampleEdge;

  assign divLim     = DIV_W'((32'd1 << clkd) - 32'd1);
  assign tick       = busy && (divCnt == divLim);
  assign lastEdge   = (edgeCnt == {wlm1, 1'b1});
  // even edge count = leading edge; phase 0 samples leading, phase 1 trailing
  assign sampleEdge = (~edgeCnt[0]) ^ cpha;
  assign done       = tick && lastEdge;
  assign rxWord     = cpha ? {rxSh[DW-2:0], miso} : rxSh;
  assign sclk       = cpol ^ phase;
  assign mosi       = mosiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      txSh    <= '0;
      rxSh    <= '0;
      mosiQ   <= 1'b0;
    end else if (cmd.abort) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (cmd.start) begin
      busy    <= 1'b1;
      phase   <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      rxSh    <= '0;
      if (!cpha) begin
        mosiQ <= loadWord[DW-1];
        txSh  <= loadWord << 1;
      end else begin
        txSh  <= loadWord;
      end
    end else if (busy) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        phase   <= ~phase;
        edgeCnt <= edgeCnt + 1'b1;
        if (lastEdge) busy <= 1'b0;
        if (sampleEdge) begin
          rxSh <= {rxSh[DW-2:0], miso};
        end else begin
          mosiQ <= txSh[DW-1];
          txSh  <= txSh << 1;
        end
      end
    end
  end
endmodule

// File: rtl/spich_ctrl.sv
module spich_ctrl
  import spich_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int CLKD_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [AW-1:0]         regAddr,
  input  logic [DW-1:0]         regWdata,
  output logic [DW-1:0]         regRdata,
  input  logic                  dpBusy,
  input  logic                  dpDone,
  input  logic [DW-1:0]         dpRxWord,
  output dpCmd_t                cmd,
  output logic [DW-1:0]         loadWord,
  output logic [$clog2(DW)-1:0] wlm1,
  output logic [CLKD_W-1:0]     clkd,
  output logic                  cpol,
  output logic                  cpha,
  output logic                  csOut,
  output logic                  txDmaReq,
  output logic                  rxDmaReq,
  output logic                  chanEn,
  output logic                  rxFull,
  output logic                  txFull,
  output logic [DW-1:0]         rxData
);
  localparam int WL_W = $clog2(DW);

  logic [DW-1:0]   cfgQ;
  logic [DW-1:0]   txBuf;
  logic [WL_W-1:0] wlField;
  xferMode_e       mode;
  logic            eot;
  logic            canStart;

  assign wlField = cfgQ[CFG_WL_LO +: WL_W];
  assign wlm1    = (wlField < WL_W'(3)) ? WL_W'(3) : wlField;
  assign clkd    = cfgQ[CFG_DIV_LO +: CLKD_W];
  assign cpol    = cfgQ[CFG_POL];
  assign cpha    = cfgQ[CFG_PHASE];
  assign mode    = xferMode_e'(cfgQ[CFG_MODE_LO +: 2]);
  assign csOut   = cfgQ[CFG_FORCE] ? ~cfgQ[CFG_CSLOW] : cfgQ[CFG_CSLOW];
  assign eot     = ~dpBusy & ~txFull;

  always_comb begin
    if (mode == XFER_RXONLY) canStart = ~rxFull;
    else canStart = txFull & ((mode == XFER_TXONLY) | ~rxFull);
  end

  assign cmd.start = chanEn & ~dpBusy & canStart;
  assign cmd.abort = ~chanEn;
  assign loadWord  = txBuf << (WL_W'(DW - 1) - wlm1);

  assign txDmaReq = cfgQ[CFG_TXREQ] & chanEn & ~txFull & (mode != XFER_RXONLY);
  assign rxDmaReq = cfgQ[CFG_RXREQ] & rxFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= '0;
      chanEn <= 1'b0;
      txBuf  <= '0;
      txFull <= 1'b0;
      rxData <= '0;
      rxFull <= 1'b0;
    end else begin
      if (regWr && regAddr == AW'(ADDR_CFG)) cfgQ <= regWdata;
      if (regWr && regAddr == AW'(ADDR_CTRL)) chanEn <= regWdata[0];
      if (cmd.start && mode != XFER_RXONLY) txFull <= 1'b0;
      if (regWr && regAddr == AW'(ADDR_TX) && chanEn) begin
        txBuf <= regWdata;
        if (mode != XFER_RXONLY) txFull <= 1'b1;
      end
      if (!chanEn) begin
        rxFull <= 1'b0;
      end else begin
        if (regRd && regAddr == AW'(ADDR_RX)) rxFull <= 1'b0;
        if (dpDone && mode != XFER_TXONLY) begin
          rxFull <= 1'b1;
          rxData <= dpRxWord;
        end
      end
    end
  end

  always_comb begin
    case (regAddr)
      AW'(ADDR_CFG):    regRdata = cfgQ;
      AW'(ADDR_STATUS): regRdata = DW'({eot, ~txFull, rxFull});
      AW'(ADDR_CTRL):   regRdata = DW'(chanEn);
      AW'(ADDR_TX):     regRdata = txBuf;
      AW'(ADDR_RX):     regRdata = rxData;
      default:          regRdata = '0;
    endcase
  end
endmodule

// File: rtl/spich_top.sv
module spich_top
  import spich_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int CLKD_W = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          csOut,
  output logic          txDmaReq,
  output logic          rxDmaReq
);
  localparam int WL_W = $clog2(DW);

  dpCmd_t            cmd;
  logic [DW-1:0]     loadWord;
  logic [WL_W-1:0]   wlm1;
  logic [CLKD_W-1:0] clkd;
  logic              cpol, cpha;
  logic              dpBusy, dpDone;
  logic [DW-1:0]     dpRxWord;
  logic              chanEn, rxFull, txFull;
  logic [DW-1:0]     rxData;
  logic              startStb;

  assign startStb = cmd.start;

  spich_ctrl #(.DW(DW), .AW(AW), .CLKD_W(CLKD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dpBusy(dpBusy), .dpDone(dpDone),
    .dpRxWord(dpRxWord), .cmd(cmd), .loadWord(loadWord), .wlm1(wlm1),
    .clkd(clkd), .cpol(cpol), .cpha(cpha), .csOut(csOut), .txDmaReq(txDmaReq),
    .rxDmaReq(rxDmaReq), .chanEn(chanEn), .rxFull(rxFull), .txFull(txFull),
    .rxData(rxData)
  );

  spich_dp #(.DW(DW), .CLKD_W(CLKD_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadWord(loadWord), .wlm1(wlm1),
    .clkd(clkd), .cpol(cpol), .cpha(cpha), .miso(miso), .busy(dpBusy),
    .done(dpDone), .rxWord(dpRxWord), .sclk(sclk), .mosi(mosi)
  );
endmodule

// File: rtl/spich_checker.sv
module spich_checker
  import spich_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          regRd,
  input logic [AW-1:0] regAddr,
  input logic          busy,
  input logic          start,
  input logic          sclk,
  input logic          cpol,
  input logic          chanEn,
  input logic          rxFull,
  input logic          txFull,
  input logic [DW-1:0] rxData,
  input logic          txDmaReq
);
  logic rxRead;
  assign rxRead = regRd && (regAddr == AW'(ADDR_RX));

  // R4: serial clock rests at the polarity level between words
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk == cpol));

  // R2: a word only begins after a start strobe from the control side
  a_r2_start_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R9: disabling discards the received word
  a_r9_disable_discard: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !rxFull);

  // R10: a held receive word is neither dropped nor overwritten
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && chanEn && !rxRead) |=> (rxFull && $stable(rxData)));

  // R11: transmit request only when the transmit register is empty
  a_r11_txreq_empty: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> !txFull);
endmodule

bind spich_top spich_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .regRd(regRd), .regAddr(regAddr), .busy(dpBusy),
  .start(startStb), .sclk(sclk), .cpol(cpol), .chanEn(chanEn),
  .rxFull(rxFull), .txFull(txFull), .rxData(rxData), .txDmaReq(txDmaReq)
);

// File: tb/tb_spich_top.sv
module tb_spich_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [7:0]  regAddr = 8'h0;
  logic [31:0] regWdata = 32'h0;
  logic [31:0] regRdata;
  logic        sclk, mosi, miso, csOut, txDmaReq, rxDmaReq;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign miso = ~mosi;

  spich_top dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csOut(csOut), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  localparam logic [7:0] A_CFG = 8'h2C, A_ST = 8'h30, A_CTL = 8'h34,
                         A_TX = 8'h38, A_RX = 8'h3C;

  // capture of serial output at the sample edge
  bit          capOn = 0;
  bit          bCpol = 0, bCpha = 0;
  logic [31:0] capWord = 0;
  int          capCnt = 0;
  longint      cyc = 0;
  bit          measOn = 0;
  longint      riseT[2];
  int          riseN = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge sclk) begin
    if (capOn && (bCpol == bCpha)) begin
      capWord = {capWord[30:0], mosi};
      capCnt++;
    end
    if (measOn && riseN < 2) begin
      riseT[riseN] = cyc;
      riseN++;
    end
  end
  always @(negedge sclk) begin
    if (capOn && (bCpol != bCpha)) begin
      capWord = {capWord[30:0], mosi};
      capCnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic poll(input int bitIdx, input logic val, output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(A_ST, s);
      if (s[bitIdx] == val) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] mkCfg(input bit cpol, input bit cpha, input logic [3:0] div,
                                        input bit csLow, input logic [4:0] wlm1,
                                        input logic [1:0] mode, input bit txReq,
                                        input bit rxReq, input bit force_);
    return {11'b0, force_, 4'b0, rxReq, txReq, mode, wlm1, csLow, div, cpol, cpha};
  endfunction

  typedef struct packed {
    logic        cpol;
    logic        cpha;
    logic [4:0]  wlm1;
    logic [3:0]  div;
    logic [1:0]  mode;
    logic [31:0] tx;
    logic [31:0] expMosi;
    logic [31:0] expRx;
    logic [5:0]  bits;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b0, 5'd7,  4'd0, 2'b00, 32'h000000A5, 32'h000000A5, 32'h0000005A, 6'd8},
    '{1'b0, 1'b1, 5'd11, 4'd1, 2'b00, 32'h000009C3, 32'h000009C3, 32'h0000063C, 6'd12},
    '{1'b1, 1'b0, 5'd15, 4'd2, 2'b00, 32'h00001234, 32'h00001234, 32'h0000EDCB, 6'd16},
    '{1'b1, 1'b1, 5'd31, 4'd0, 2'b00, 32'hDEADBEEF, 32'hDEADBEEF, 32'h21524110, 6'd32},
    '{1'b0, 1'b0, 5'd1,  4'd1, 2'b00, 32'h00000FFA, 32'h0000000A, 32'h00000005, 6'd4},
    '{1'b0, 1'b1, 5'd7,  4'd0, 2'b10, 32'h0000003C, 32'h0000003C, 32'h00000000, 6'd8},
    '{1'b0, 1'b0, 5'd4,  4'd0, 2'b00, 32'h00000013, 32'h00000013, 32'h0000000C, 6'd5}
  };

  function automatic logic [31:0] maskBits(input int n);
    return (n >= 32) ? 32'hFFFFFFFF : ((32'd1 << n) - 32'd1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit ok;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    rd(A_ST, d);  check("R1 status after reset", d, 32'h6);
    check("R1 sclk after reset", {31'b0, sclk}, 32'h0);
    check("R1 cs after reset", {31'b0, csOut}, 32'h0);
    check("R11 dma idle after reset", {30'b0, txDmaReq, rxDmaReq}, 32'h0);
    wr(A_CFG, 32'h0012_3456);
    rd(A_CFG, d); check("R1 cfg readback", d, 32'h0012_3456);
    wr(A_CFG, 32'h0);

    // vector table: R2 R3 R4 R7 R12
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      capOn = 0;
      wr(A_CTL, 0);
      bCpol = v.cpol; bCpha = v.cpha;
      wr(A_CFG, mkCfg(v.cpol, v.cpha, v.div, 1, v.wlm1, v.mode, 0, 0, 1));
      wr(A_CTL, 1);
      capWord = 0; capCnt = 0; capOn = 1;
      wr(A_TX, v.tx);
      if (v.mode == 2'b10) begin
        poll(2, 1'b1, ok);
        check("R12 tx-only word finished", {31'b0, ok}, 32'h1);
        rd(A_ST, d); check("R12 tx-only stores no receive word", d & 32'h1, 32'h0);
      end else begin
        poll(0, 1'b1, ok);
        check("R7 receive flag set", {31'b0, ok}, 32'h1);
        rd(A_RX, d); check("R7 received word", d, v.expRx);
        rd(A_ST, d); check("R7 read clears flag", d & 32'h1, 32'h0);
      end
      check("R3 bits shifted", capCnt, 32'(v.bits));
      check("R2 R4 serial output MSB first", capWord & maskBits(int'(v.bits)), v.expMosi);
      check("R4 sclk idle level", {31'b0, sclk}, {31'b0, v.cpol});
    end
    capOn = 0;

    // R5 divider period
    wr(A_CTL, 0);
    bCpol = 0; bCpha = 0;
    wr(A_CFG, mkCfg(0, 0, 4'd3, 1, 5'd7, 2'b00, 0, 0, 1));
    wr(A_CTL, 1);
    riseN = 0; measOn = 1;
    wr(A_TX, 32'h55);
    poll(0, 1'b1, ok);
    measOn = 0;
    check("R5 sclk period cycles", 32'(riseT[1] - riseT[0]), 32'd16);
    rd(A_RX, d);

    // R12 end-of-transfer separate from transmit-empty
    wr(A_CFG, mkCfg(0, 0, 4'd4, 1, 5'd7, 2'b00, 0, 0, 1));
    wr(A_TX, 32'h0F);
    repeat (10) @(posedge clk);
    rd(A_ST, d); check("R12 mid-word status", d & 32'h6, 32'h2);
    poll(0, 1'b1, ok);
    rd(A_RX, d);

    // R6 chip select
    wr(A_CFG, mkCfg(0, 0, 0, 1, 5'd7, 0, 0, 0, 1)); #1;
    check("R6 forced active-low", {31'b0, csOut}, 32'h0);
    wr(A_CFG, mkCfg(0, 0, 0, 1, 5'd7, 0, 0, 0, 0)); #1;
    check("R6 released active-low, enabled", {31'b0, csOut}, 32'h1);
    wr(A_CFG, mkCfg(0, 0, 0, 0, 5'd7, 0, 0, 0, 1)); #1;
    check("R6 forced active-high", {31'b0, csOut}, 32'h1);

    // R10 hold-off and R11 requests
    bCpol = 0; bCpha = 0;
    wr(A_CTL, 0);
    wr(A_CFG, mkCfg(0, 0, 0, 1, 5'd7, 2'b00, 1, 1, 1));
    wr(A_CTL, 1); #1;
    check("R11 tx request when empty", {31'b0, txDmaReq}, 32'h1);
    capWord = 0; capCnt = 0; capOn = 1;
    wr(A_TX, 32'h81);
    poll(0, 1'b1, ok);
    #1 check("R11 rx request when full", {31'b0, rxDmaReq}, 32'h1);
    wr(A_TX, 32'h42);
    repeat (60) @(posedge clk);
    rd(A_ST, d); check("R10 pending word held", d & 32'h3, 32'h1);
    check("R10 no extra bits while full", capCnt, 32'd8);
    #1 check("R11 no tx request while full", {31'b0, txDmaReq}, 32'h0);
    rd(A_RX, d); check("R10 first word intact", d, 32'h7E);
    poll(0, 1'b1, ok);
    rd(A_RX, d); check("R10 second word after read", d, 32'hBD);
    check("R10 second word shifted", capCnt, 32'd16);

    // R9 disable discards; transmit write while disabled ignored (R2)
    wr(A_TX, 32'h99);
    poll(0, 1'b1, ok);
    wr(A_CTL, 0);
    rd(A_ST, d); check("R9 disable clears receive flag", d & 32'h1, 32'h0);
    capCnt = 0;
    wr(A_TX, 32'h77);
    rd(A_ST, d); check("R2 write while disabled ignored", d & 32'h6, 32'h6);
    wr(A_CTL, 1);
    repeat (40) @(posedge clk);
    rd(A_ST, d); check("R9 no stale word after re-enable", d & 32'h1, 32'h0);
    check("R2 nothing shifted after ignored write", capCnt, 32'd0);

    // R8 receive-only: resend last transmit value, stall while full
    wr(A_CFG, mkCfg(0, 0, 0, 1, 5'd7, 2'b10, 0, 0, 1));
    wr(A_TX, 32'h3C);
    poll(2, 1'b1, ok);
    wr(A_CTL, 0);
    wr(A_CFG, mkCfg(0, 0, 0, 1, 5'd7, 2'b01, 0, 0, 1));
    capWord = 0; capCnt = 0;
    wr(A_CTL, 1);
    poll(0, 1'b1, ok);
    repeat (80) @(posedge clk);
    check("R8 stalls while receive full", capCnt, 32'd8);
    check("R8 resent last transmit value", capWord & 32'hFF, 32'h3C);
    rd(A_RX, d); check("R8 receive-only word", d, 32'hC3);
    poll(0, 1'b1, ok);
    check("R8 next word starts after read", capCnt, 32'd16);
    rd(A_RX, d); check("R8 second receive-only word", d, 32'hC3);
    wr(A_CTL, 0);
    capOn = 0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule